// File: doc/BRIEF.md
# Auto-Increment Indirect Memory Window

This block gives a host a narrow register window onto two internal spaces that are not mapped directly: a synchronous SRAM and a peripheral register space. The host first loads an address register, then reads or writes the matching data register. Each SRAM data access moves its pointer on by one dword. The read pointer and the write pointer are separate, so a stream of reads and a stream of writes can be interleaved without either being disturbed.

Peripheral address registers hold a 16-bit register offset and a 2-bit field that gives the access size as the byte count minus one. Peripheral data accesses turn that size into byte enables. Peripheral pointers do not advance.

The host uses a single-cycle request pulse and gets back a single-cycle acknowledge pulse that carries the read data. Plain register accesses are acknowledged on the next cycle. A read of SRAM data holds back the acknowledge until the SRAM returns its word. Every peripheral data access holds back the acknowledge until the peripheral answers.

The controller is a three-state machine:
- `ST_IDLE` accepts requests.
- `ST_MEM_WAIT` waits for SRAM read data. It returns to `ST_IDLE` on `mem_rvalid`.
- `ST_PER_WAIT` waits for the peripheral. It returns to `ST_IDLE` on `per_ack`.

`ST_IDLE` goes to `ST_MEM_WAIT` on a host read of offset 0x1C. It goes to `ST_PER_WAIT` on a host write of 0x4C or a host read of 0x50. Every other request stays in `ST_IDLE`.

Top module: `memwin_bridge`

## Requirements
- R1: After reset, `hst_ack`, `mem_req` and `per_req` are low, and the four address registers (0x0C, 0x10, 0x44, 0x48) read as zero.
- R2: A host access to a plain register, or to an unmapped offset, is acknowledged by a one-cycle `hst_ack` pulse in the cycle after the request. An unmapped offset reads as zero, and a write to it has no effect.
- R3: A host read of offset 0x1C issues an SRAM read at the read pointer. `hst_ack` stays low until `mem_rvalid` arrives, and is then raised in the following cycle with the SRAM word on `hst_rdata`. Only then does the read pointer grow by 4 (one dword, byte addressing).
- R4: The read pointer (0x0C) and the write pointer (0x10) are independent. Loading either one, or accessing either data register, leaves the other pointer unchanged.
- R5: A host write of offset 0x18 issues an SRAM write of `hst_wdata` at the write pointer. It is acknowledged in the next cycle, and the write pointer grows by 4.
- R6: Offsets 0x0C and 0x10 hold a full 32-bit address that reads back exactly as it was written.
- R7: The peripheral write address register (0x44) and read address register (0x48) keep bits 15:0 as the register offset and bits 25:24 as the byte count minus one. All other bits read back as zero. Neither register changes on a data access.
- R8: A host write of 0x4C or read of 0x50 issues one peripheral request at the stored offset. Its byte enables have the low count+1 bits set. `hst_ack` follows in the cycle after `per_ack`, and a read returns `per_rdata`.
- R9: A write to a read-data offset (0x1C, 0x50) or a read of a write-data offset (0x18, 0x4C) starts no SRAM or peripheral access and moves no pointer. It is acknowledged like a plain register, and such a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_req | input | 1 | Host request pulse |
| hst_we | input | 1 | Host request is a write |
| hst_addr | input | 8 | Byte offset within the window |
| hst_wdata | input | 32 | Host write data |
| hst_ack | output | 1 | Access complete pulse |
| hst_rdata | output | 32 | Read data, valid with `hst_ack` |
| mem_req | output | 1 | SRAM access strobe |
| mem_we | output | 1 | SRAM write when high |
| mem_addr | output | 32 | SRAM byte address |
| mem_wdata | output | 32 | SRAM write data |
| mem_rdata | input | 32 | SRAM read data |
| mem_rvalid | input | 1 | SRAM read data valid |
| per_req | output | 1 | Peripheral access strobe |
| per_we | output | 1 | Peripheral write when high |
| per_addr | output | 16 | Peripheral register offset |
| per_be | output | 4 | Peripheral byte enables |
| per_wdata | output | 32 | Peripheral write data |
| per_rdata | input | 32 | Peripheral read data |
| per_ack | input | 1 | Peripheral access complete |

## Verification
The assertions assume a well-behaved host and well-behaved targets:
- The host raises no new request until it has seen the acknowledge for the previous one.
- `mem_rvalid` arrives only for an outstanding SRAM read, and at least one cycle after `mem_req`.
- `per_ack` arrives only for an outstanding peripheral request.

The bench keeps within these rules. Its host task waits for each acknowledge before it issues the next pulse. Its SRAM model answers reads after a fixed latency of three cycles, and its peripheral model acknowledges one cycle after each request.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MEM_WAIT,
        ST_PER_WAIT
    } win_state_t;

    localparam int HOST_AW = 8;

    localparam logic [HOST_AW-1:0] OFS_MEM_RADDR = 8'h0C;
    localparam logic [HOST_AW-1:0] OFS_MEM_WADDR = 8'h10;
    localparam logic [HOST_AW-1:0] OFS_MEM_WDAT  = 8'h18;
    localparam logic [HOST_AW-1:0] OFS_MEM_RDAT  = 8'h1C;
    localparam logic [HOST_AW-1:0] OFS_PER_WADDR = 8'h44;
    localparam logic [HOST_AW-1:0] OFS_PER_RADDR = 8'h48;
    localparam logic [HOST_AW-1:0] OFS_PER_WDAT  = 8'h4C;
    localparam logic [HOST_AW-1:0] OFS_PER_RDAT  = 8'h50;
endpackage

// File: rtl/iwin_ptr.sv
module iwin_ptr #(
    parameter int W    = 32,
    parameter int STEP = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         adv,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] STEP_V = W'(STEP);

    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= load_val;
        else if (adv)  q <= q + STEP_V;
    end
endmodule

// File: rtl/iwin_be_dec.sv
module iwin_be_dec #(
    parameter int CNT_W = 2,
    parameter int BE_W  = 4
) (
    input  logic [CNT_W-1:0] cnt,
    output logic [BE_W-1:0]  be
);
    always_comb begin
        for (int i = 0; i < BE_W; i++) begin
            be[i] = (i <= int'(cnt));
        end
    end
endmodule

// File: rtl/memwin_bridge.sv
module memwin_bridge
    import memwin_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int MEM_AW   = 32,
    parameter int PER_AW   = 16,
    parameter int CNT_W    = 2,
    parameter int CNT_LSB  = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hst_req,
    input  logic                hst_we,
    input  logic [HOST_AW-1:0]  hst_addr,
    input  logic [DATA_W-1:0]   hst_wdata,
    output logic                hst_ack,
    output logic [DATA_W-1:0]   hst_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [MEM_AW-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic                mem_rvalid,
    output logic                per_req,
    output logic                per_we,
    output logic [PER_AW-1:0]   per_addr,
    output logic [DATA_W/8-1:0] per_be,
    output logic [DATA_W-1:0]   per_wdata,
    input  logic [DATA_W-1:0]   per_rdata,
    input  logic                per_ack
);
    localparam int BE_W    = DATA_W / 8;
    localparam int STEP    = DATA_W / 8;
    localparam int NUM_PTR = 2;
    localparam int RD_IDX  = 0;
    localparam int WR_IDX  = 1;

    win_state_t state_q, state_d;

    logic [MEM_AW-1:0] ptr_q   [NUM_PTR];
    logic              ptr_ld  [NUM_PTR];
    logic              ptr_adv [NUM_PTR];

    logic [PER_AW-1:0] pw_ofs_q, pr_ofs_q;
    logic [CNT_W-1:0]  pw_cnt_q, pr_cnt_q;
    logic [BE_W-1:0]   pw_be, pr_be;
    logic [DATA_W-1:0] rb_val;

    logic take;
    assign take = hst_req && (state_q == ST_IDLE);

    function automatic logic [DATA_W-1:0] pack_per(input logic [PER_AW-1:0] ofs,
                                                   input logic [CNT_W-1:0]  cnt);
        logic [DATA_W-1:0] v;
        v = '0;
        v[PER_AW-1:0] = ofs;
        v[CNT_LSB +: CNT_W] = cnt;
        return v;
    endfunction

    // address pointers: index 0 feeds reads, index 1 feeds writes
    assign ptr_ld[RD_IDX]  = take && hst_we && (hst_addr == OFS_MEM_RADDR);
    assign ptr_adv[RD_IDX] = (state_q == ST_MEM_WAIT) && mem_rvalid;
    assign ptr_ld[WR_IDX]  = take && hst_we && (hst_addr == OFS_MEM_WADDR);
    assign ptr_adv[WR_IDX] = take && hst_we && (hst_addr == OFS_MEM_WDAT);

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        iwin_ptr #(.W(MEM_AW), .STEP(STEP)) u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ptr_ld[g]),
            .load_val (hst_wdata[MEM_AW-1:0]),
            .adv      (ptr_adv[g]),
            .q        (ptr_q[g])
        );
    end

    iwin_be_dec #(.CNT_W(CNT_W), .BE_W(BE_W)) u_be_w (.cnt(pw_cnt_q), .be(pw_be));
    iwin_be_dec #(.CNT_W(CNT_W), .BE_W(BE_W)) u_be_r (.cnt(pr_cnt_q), .be(pr_be));

    always_comb begin
        unique case (hst_addr)
            OFS_MEM_RADDR: rb_val = DATA_W'(ptr_q[RD_IDX]);
            OFS_MEM_WADDR: rb_val = DATA_W'(ptr_q[WR_IDX]);
            OFS_PER_WADDR: rb_val = pack_per(pw_ofs_q, pw_cnt_q);
            OFS_PER_RADDR: rb_val = pack_per(pr_ofs_q, pr_cnt_q);
            default:       rb_val = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take && !hst_we && hst_addr == OFS_MEM_RDAT)
                    state_d = ST_MEM_WAIT;
                else if (take && ((hst_we && hst_addr == OFS_PER_WDAT) ||
                                  (!hst_we && hst_addr == OFS_PER_RDAT)))
                    state_d = ST_PER_WAIT;
            end
            ST_MEM_WAIT: if (mem_rvalid) state_d = ST_IDLE;
            ST_PER_WAIT: if (per_ack)    state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs and window registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hst_ack   <= 1'b0;
            hst_rdata <= '0;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            per_req   <= 1'b0;
            per_we    <= 1'b0;
            per_addr  <= '0;
            per_be    <= '0;
            per_wdata <= '0;
            pw_ofs_q  <= '0;
            pw_cnt_q  <= '0;
            pr_ofs_q  <= '0;
            pr_cnt_q  <= '0;
        end else begin
            hst_ack <= 1'b0;
            mem_req <= 1'b0;
            per_req <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (take) begin
                    case (hst_addr)
                        OFS_MEM_RDAT: begin
                            if (!hst_we) begin
                                mem_req  <= 1'b1;
                                mem_we   <= 1'b0;
                                mem_addr <= ptr_q[RD_IDX];
                            end else begin
                                hst_ack <= 1'b1;
                            end
                        end
                        OFS_MEM_WDAT: begin
                            hst_ack   <= 1'b1;
                            hst_rdata <= '0;
                            if (hst_we) begin
                                mem_req   <= 1'b1;
                                mem_we    <= 1'b1;
                                mem_addr  <= ptr_q[WR_IDX];
                                mem_wdata <= hst_wdata;
                            end
                        end
                        OFS_PER_WDAT: begin
                            if (hst_we) begin
                                per_req   <= 1'b1;
                                per_we    <= 1'b1;
                                per_addr  <= pw_ofs_q;
                                per_be    <= pw_be;
                                per_wdata <= hst_wdata;
                            end else begin
                                hst_ack   <= 1'b1;
                                hst_rdata <= '0;
                            end
                        end
                        OFS_PER_RDAT: begin
                            if (!hst_we) begin
                                per_req  <= 1'b1;
                                per_we   <= 1'b0;
                                per_addr <= pr_ofs_q;
                                per_be   <= pr_be;
                            end else begin
                                hst_ack <= 1'b1;
                            end
                        end
                        default: begin
                            hst_ack <= 1'b1;
                            if (hst_we) begin
                                if (hst_addr == OFS_PER_WADDR) begin
                                    pw_ofs_q <= hst_wdata[PER_AW-1:0];
                                    pw_cnt_q <= hst_wdata[CNT_LSB +: CNT_W];
                                end
                                if (hst_addr == OFS_PER_RADDR) begin
                                    pr_ofs_q <= hst_wdata[PER_AW-1:0];
                                    pr_cnt_q <= hst_wdata[CNT_LSB +: CNT_W];
                                end
                            end else begin
                                hst_rdata <= rb_val;
                            end
                        end
                    endcase
                end
                ST_MEM_WAIT: if (mem_rvalid) begin
                    hst_ack   <= 1'b1;
                    hst_rdata <= mem_rdata;
                end
                ST_PER_WAIT: if (per_ack) begin
                    hst_ack   <= 1'b1;
                    hst_rdata <= per_we ? '0 : per_rdata;
                end
                default: ;
            endcase
        end
    end

    // R2: completion is a single pulse
    a_r2_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        hst_ack |=> !hst_ack);

    // R3: no completion while SRAM data is still outstanding
    a_r3_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEM_WAIT && !mem_rvalid) |=> !hst_ack);

    // R3: read pointer steps one dword once data returns
    a_r3_rd_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEM_WAIT && mem_rvalid) |=>
            ptr_q[RD_IDX] == $past(ptr_q[RD_IDX]) + MEM_AW'(STEP));

    // R5: the issued write address is one dword behind the write pointer
    a_r5_wr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ptr_q[WR_IDX] == mem_addr + MEM_AW'(STEP));

    // R8: byte enables are a contiguous run from lane 0
    a_r8_be_contig: assert property (@(posedge clk) disable iff (!rst_n)
        per_req |-> (per_be != '0) &&
            (per_be == ({BE_W{1'b1}} >> (BE_W - $countones(per_be)))));

    // R3: one SRAM read outstanding at a time
    a_r3_single_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !mem_req);
endmodule

// File: tb/memwin_bridge_test.sv
module memwin_bridge_test;
    localparam int CLK_PERIOD = 10;
    localparam int SRAM_LAT   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_req = 1'b0;
    logic        hst_we = 1'b0;
    logic [7:0]  hst_addr = '0;
    logic [31:0] hst_wdata = '0;
    logic        hst_ack;
    logic [31:0] hst_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_rvalid;
    logic        per_req, per_we;
    logic [15:0] per_addr;
    logic [3:0]  per_be;
    logic [31:0] per_wdata;
    logic [31:0] per_rdata;
    logic        per_ack;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memwin_bridge uut (
        .clk(clk), .rst_n(rst_n),
        .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_ack(hst_ack), .hst_rdata(hst_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .per_req(per_req), .per_we(per_we), .per_addr(per_addr), .per_be(per_be),
        .per_wdata(per_wdata), .per_rdata(per_rdata), .per_ack(per_ack)
    );

    // behavioural SRAM, 64 dwords, fixed read latency
    logic [31:0] sram [64];
    int          pend;
    logic [31:0] paddr;
    int          mem_cnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) sram[i] <= '0;
            pend <= 0; mem_rvalid <= 1'b0; mem_rdata <= '0; mem_cnt <= 0;
        end else begin
            mem_rvalid <= 1'b0;
            if (mem_req) mem_cnt <= mem_cnt + 1;
            if (mem_req && mem_we) sram[mem_addr[7:2]] <= mem_wdata;
            if (mem_req && !mem_we) begin
                pend <= SRAM_LAT - 1; paddr <= mem_addr;
            end else if (pend != 0) begin
                pend <= pend - 1;
                if (pend == 1) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= sram[paddr[7:2]];
                end
            end
        end
    end

    // behavioural peripheral: 16 registers, byte-enabled writes
    localparam logic [31:0] PER_INIT = 32'h11223344;
    logic [31:0] preg [16];
    logic [3:0]  last_be;
    logic [15:0] last_paddr;
    int          per_cnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) preg[i] <= PER_INIT;
            per_ack <= 1'b0; per_rdata <= '0; per_cnt <= 0;
            last_be <= '0; last_paddr <= '0;
        end else begin
            per_ack <= 1'b0;
            if (per_req) begin
                per_cnt <= per_cnt + 1;
                per_ack <= 1'b1;
                last_be <= per_be;
                last_paddr <= per_addr;
                per_rdata <= preg[per_addr[5:2]];
                if (per_we)
                    for (int b = 0; b < 4; b++)
                        if (per_be[b]) preg[per_addr[5:2]][8*b +: 8] <= per_wdata[8*b +: 8];
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_op(input logic we, input logic [7:0] a, input logic [31:0] d,
                           output logic [31:0] rd, output int waits);
        @(negedge clk);
        hst_req = 1'b1; hst_we = we; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_req = 1'b0;
        waits = 0;
        while (!hst_ack && waits < 100) begin
            @(negedge clk);
            waits++;
        end
        rd = hst_rdata;
        if (waits >= 100) begin
            errors++;
            $display("FAIL R2: no acknowledge at offset %h", a);
        end
    endtask

    task automatic t_reset();
        logic [31:0] r; int w;
        chk("R1 ack", {31'b0, hst_ack}, 32'd0);
        chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
        chk("R1 per_req", {31'b0, per_req}, 32'd0);
        host_op(1'b0, 8'h0C, '0, r, w); chk("R1 raddr", r, 32'd0);
        chk("R2 reg ack latency", w, 0);
        host_op(1'b0, 8'h10, '0, r, w); chk("R1 waddr", r, 32'd0);
        host_op(1'b0, 8'h44, '0, r, w); chk("R1 per waddr", r, 32'd0);
        host_op(1'b0, 8'h48, '0, r, w); chk("R1 per raddr", r, 32'd0);
    endtask

    task automatic t_mem_write();
        logic [31:0] r; int w;
        host_op(1'b1, 8'h10, 32'h0000_0040, r, w);
        host_op(1'b1, 8'h18, 32'hA000_0001, r, w);
        chk("R5 write ack latency", w, 0);
        host_op(1'b1, 8'h18, 32'hA000_0002, r, w);
        host_op(1'b1, 8'h18, 32'hA000_0003, r, w);
        @(negedge clk);
        chk("R5 sram[0x40]", sram[16], 32'hA000_0001);
        chk("R5 sram[0x44]", sram[17], 32'hA000_0002);
        chk("R5 sram[0x48]", sram[18], 32'hA000_0003);
        host_op(1'b0, 8'h10, '0, r, w); chk("R5 waddr advanced", r, 32'h0000_004C);
        host_op(1'b1, 8'h0C, 32'hDEAD_BEE0, r, w);
        host_op(1'b0, 8'h0C, '0, r, w); chk("R6 full 32-bit raddr", r, 32'hDEAD_BEE0);
    endtask

    task automatic t_mem_read();
        logic [31:0] r; int w;
        host_op(1'b1, 8'h0C, 32'h0000_0040, r, w);
        host_op(1'b0, 8'h1C, '0, r, w);
        chk("R3 data 0", r, 32'hA000_0001);
        chk("R3 stall cycles", w, SRAM_LAT + 1);
        host_op(1'b0, 8'h1C, '0, r, w); chk("R3 data 1", r, 32'hA000_0002);
        host_op(1'b0, 8'h1C, '0, r, w); chk("R3 data 2", r, 32'hA000_0003);
        host_op(1'b0, 8'h0C, '0, r, w); chk("R3 raddr advanced", r, 32'h0000_004C);
    endtask

    task automatic t_interleave();
        logic [31:0] r; int w;
        host_op(1'b1, 8'h0C, 32'h0000_0044, r, w);
        host_op(1'b1, 8'h10, 32'h0000_0080, r, w);
        host_op(1'b0, 8'h0C, '0, r, w); chk("R4 raddr kept after waddr load", r, 32'h0000_0044);
        host_op(1'b1, 8'h18, 32'h5555_AAAA, r, w);
        host_op(1'b0, 8'h1C, '0, r, w); chk("R4 read unaffected by write", r, 32'hA000_0002);
        host_op(1'b1, 8'h18, 32'h6666_BBBB, r, w);
        host_op(1'b0, 8'h0C, '0, r, w); chk("R4 raddr", r, 32'h0000_0048);
        host_op(1'b0, 8'h10, '0, r, w); chk("R4 waddr", r, 32'h0000_0088);
        @(negedge clk);
        chk("R4 sram[0x84]", sram[33], 32'h6666_BBBB);
    endtask

    task automatic t_periph();
        logic [31:0] r; int w;
        host_op(1'b1, 8'h44, 32'hFD5A_0008, r, w);
        host_op(1'b0, 8'h44, '0, r, w); chk("R7 per waddr fields", r, 32'h0100_0008);
        host_op(1'b1, 8'h4C, 32'hAABB_CCDD, r, w);
        chk("R8 write ack after per_ack", w, 2);
        chk("R8 be count 2", {28'b0, last_be}, 32'h3);
        chk("R8 offset", {16'b0, last_paddr}, 32'h0008);
        chk("R8 partial write", preg[2], 32'h1122_CCDD);
        host_op(1'b0, 8'h44, '0, r, w); chk("R7 no advance", r, 32'h0100_0008);
        host_op(1'b1, 8'h48, 32'h0300_0008, r, w);
        host_op(1'b0, 8'h50, '0, r, w);
        chk("R8 read data", r, 32'h1122_CCDD);
        chk("R8 be full dword", {28'b0, last_be}, 32'hF);
        host_op(1'b1, 8'h44, 32'h0000_000C, r, w);
        host_op(1'b1, 8'h4C, 32'hFFFF_FF99, r, w);
        chk("R8 be count 1", {28'b0, last_be}, 32'h1);
        chk("R8 single byte", preg[3], 32'h1122_3399);
        host_op(1'b0, 8'h48, '0, r, w); chk("R7 per raddr no advance", r, 32'h0300_0008);
    endtask

    task automatic t_ignored();
        logic [31:0] r; int w; int m0, p0;
        m0 = mem_cnt; p0 = per_cnt;
        host_op(1'b1, 8'h1C, 32'h1234_5678, r, w);
        chk("R9 write rdat ack", w, 0);
        host_op(1'b0, 8'h18, '0, r, w); chk("R9 read wdat zero", r, 32'd0);
        host_op(1'b1, 8'h50, 32'h1234_5678, r, w);
        host_op(1'b0, 8'h4C, '0, r, w); chk("R9 read per wdat zero", r, 32'd0);
        @(negedge clk);
        chk("R9 no sram access", mem_cnt, m0);
        chk("R9 no per access", per_cnt, p0);
        host_op(1'b0, 8'h0C, '0, r, w); chk("R9 raddr unchanged", r, 32'h0000_0048);
        host_op(1'b0, 8'h10, '0, r, w); chk("R9 waddr unchanged", r, 32'h0000_0088);
        host_op(1'b1, 8'h04, 32'hFFFF_FFFF, r, w);
        host_op(1'b0, 8'h04, '0, r, w); chk("R2 unmapped reads zero", r, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mem_write();
        t_mem_read();
        t_interleave();
        t_periph();
        t_ignored();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule